// File: doc/BRIEF.md
# Serial-Loaded Bank Switching Controller

This block sits on a cartridge and turns the addresses of two buses into addresses of the cartridge's own memories. Program reads from the CPU in the upper 32KB window ($8000-$FFFF) become an address into a larger program ROM. Pattern reads from the picture unit in $0000-$1FFF become an address into a larger pattern memory. The block also presents a two-bit nametable mirroring code that the console side uses to fold its nametable space.

Software configures the block through CPU writes of single bits. Each write at $8000 or above with data bit 7 clear carries one bit in data bit 0, least significant bit first. The fifth such write moves the five gathered bits into one of four internal registers, picked by CPU address bits 14:13. A write with data bit 7 set abandons a partial sequence and forces the program layout back to the mode that fixes the last bank high. Mode fields in the control register choose how the program and pattern windows are split into banks. Both translated addresses come out of registers, so each one follows its input address by one clock.

Top module: `sbc_bank_ctrl`

## Requirements
- R1: After reset the control register holds 5'h0C and the other three registers hold zero. So mirror_mode is 0, CPU $8000 maps to bank 0, CPU $C000 maps to the last 16KB bank (PRG_BANKS-1), and pattern address 0 maps to 0.
- R2: A write at $8000 or above with wr_data[7] set discards any partly gathered bits. The next five bit-writes then form a complete new value.
- R3: A write with wr_data[7] set forces control bits 3:2 to 2'b11 and leaves control bits 4 and 1:0 unchanged.
- R4: The fifth write with wr_data[7] clear commits {d5,d4,d3,d2,d1}, where dN is wr_data[0] of the Nth write. The target is chosen by wr_addr[14:13]: 0 control, 1 pattern bank A, 2 pattern bank B, 3 program bank. The program bank keeps only its low 4 bits.
- R5: Writes below $8000 change neither the registers nor the count of gathered bits.
- R6: Program modes 0 and 1 (control bits 3:2) map one 32KB window. The 16KB bank is {bank[3:1], cpu_addr[14]}, so the low bit of the program bank has no effect.
- R7: Program mode 2 maps bank 0 at $8000-$BFFF and the program bank at $C000-$FFFF.
- R8: Program mode 3 maps the program bank at $8000-$BFFF and bank PRG_BANKS-1 at $C000-$FFFF.
- R9: With control bit 4 clear, one 8KB pattern bank is used. The 4KB bank is {bankA[4:1], ppu_addr[12]}.
- R10: With control bit 4 set, $0000-$0FFF uses pattern bank A and $1000-$1FFF uses pattern bank B, each a 4KB bank.
- R11: mirror_mode equals control bits 1:0, with this encoding: 0 one screen (lower), 1 one screen (upper), 2 vertical, 3 horizontal.
- R12: prg_rom_addr and chr_addr are registered. The value present after clock edge k comes from the input address and the register contents just before edge k. A commit at edge k is therefore first visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU read address |
| ppu_addr | input | 13 | Pattern read address |
| prg_rom_addr | output | PRG_AW (18) | Translated program ROM address |
| chr_addr | output | CHR_AW (17) | Translated pattern memory address |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A committing fifth write and a program address lookup can fall in the same cycle. The bench holds cpu_addr at $C000 while the fifth bit of a control value lands, which switches the program mode from 3 to 2. It then expects the bank-15 address on the first registered output, because the lookup at that edge still sees the old mode, and the newly selected bank on the following output. A scoreboard queue carries the expected values, and a monitor compares them against the outputs between clock edges.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned SBC_VAL_W  = 5;
  localparam int unsigned SBC_PRGB_W = 4;
  localparam int unsigned SBC_CNT_W  = 3;
  localparam logic [SBC_VAL_W-1:0] SBC_SHIFT_INIT = 5'b10000;
  localparam logic [SBC_VAL_W-1:0] SBC_CTRL_INIT  = 5'h0C;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_CHRA = 2'd1,
    TGT_CHRB = 2'd2,
    TGT_PRG  = 2'd3
  } sbc_tgt_e;

  typedef struct packed {
    logic [SBC_VAL_W-1:0]  ctrl;
    logic [SBC_VAL_W-1:0]  chr_a;
    logic [SBC_VAL_W-1:0]  chr_b;
    logic [SBC_PRGB_W-1:0] prg;
  } sbc_regs_t;
endpackage

// File: rtl/sbc_serial_loader.sv
module sbc_serial_loader
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output sbc_regs_t   regs
);
  localparam logic [SBC_CNT_W-1:0] LAST_CNT = SBC_CNT_W'(SBC_VAL_W - 1);

  logic [SBC_VAL_W-1:0] shift_q;
  logic [SBC_CNT_W-1:0] cnt_q;
  logic [SBC_VAL_W-1:0] shift_nxt;
  logic                 hit;
  logic                 clr_req;
  logic                 bit_req;
  logic                 commit;
  sbc_tgt_e             tgt;
  logic [3:0]           tgt_sel;
  logic                 unused_wr;

  assign unused_wr = ^{wr_addr[12:0], wr_data[6:1]};

  assign hit       = wr_en && wr_addr[15];
  assign clr_req   = hit && wr_data[7];
  assign bit_req   = hit && !wr_data[7];
  assign commit    = bit_req && (cnt_q == LAST_CNT);
  assign shift_nxt = {wr_data[0], shift_q[SBC_VAL_W-1:1]};
  assign tgt       = sbc_tgt_e'(wr_addr[14:13]);

  // one-hot commit enable per target register
  for (genvar t = 0; t < 4; t++) begin : g_sel
    assign tgt_sel[t] = commit && (tgt == sbc_tgt_e'(t));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= SBC_SHIFT_INIT;
      cnt_q      <= '0;
      regs.ctrl  <= SBC_CTRL_INIT;
      regs.chr_a <= '0;
      regs.chr_b <= '0;
      regs.prg   <= '0;
    end else if (clr_req) begin
      shift_q         <= SBC_SHIFT_INIT;
      cnt_q           <= '0;
      regs.ctrl[3:2]  <= 2'b11;
    end else if (bit_req) begin
      if (commit) begin
        shift_q <= SBC_SHIFT_INIT;
        cnt_q   <= '0;
      end else begin
        shift_q <= shift_nxt;
        cnt_q   <= cnt_q + 1'b1;
      end
      if (tgt_sel[TGT_CTRL]) regs.ctrl  <= shift_nxt;
      if (tgt_sel[TGT_CHRA]) regs.chr_a <= shift_nxt;
      if (tgt_sel[TGT_CHRB]) regs.chr_b <= shift_nxt;
      if (tgt_sel[TGT_PRG])  regs.prg   <= shift_nxt[SBC_PRGB_W-1:0];
    end
  end

  // R4: the bit counter never passes the fifth slot
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_CNT);

  // R4: a fifth bit-write empties the shifter
  p_commit_clears_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cnt_q == '0 && shift_q == SBC_SHIFT_INIT));

  // R2: a bit-7 write abandons the partial sequence
  p_clear_seq_r2: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cnt_q == '0 && shift_q == SBC_SHIFT_INIT));

  // R3: a bit-7 write forces the fixed-last program mode, keeping other fields
  p_ctrl_force_r3: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (regs.ctrl[3:2] == 2'b11 && $stable(regs.ctrl[1:0])
                 && $stable(regs.ctrl[4])));

  // R5: writes below $8000 touch nothing
  p_low_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[15]) |=> ($stable(cnt_q) && $stable(shift_q) && $stable(regs)));
endmodule

// File: rtl/sbc_prg_map.sv
module sbc_prg_map
  import sbc_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16,
  localparam int unsigned PRG_BW   = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW   = PRG_BW + 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           cpu_addr,
  input  logic [1:0]            prg_mode,
  input  logic [SBC_PRGB_W-1:0] prg_bank,
  output logic [PRG_AW-1:0]     prg_rom_addr
);
  localparam logic [SBC_VAL_W-1:0] LAST_BANK = SBC_VAL_W'(PRG_BANKS - 1);

  logic [SBC_VAL_W-1:0] bank_sel;
  logic                 hi_half;
  logic                 unused_a15;

  assign unused_a15 = cpu_addr[15];
  assign hi_half    = cpu_addr[14];

  always_comb begin
    unique case (prg_mode)
      2'd0, 2'd1: bank_sel = {1'b0, prg_bank[3:1], hi_half};
      2'd2:       bank_sel = hi_half ? {1'b0, prg_bank} : '0;
      default:    bank_sel = hi_half ? LAST_BANK : {1'b0, prg_bank};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prg_rom_addr <= '0;
    else     prg_rom_addr <= {bank_sel[PRG_BW-1:0], cpu_addr[13:0]};
  end

  // R8: upper half in mode 3 lands in the last bank
  p_fixed_last_r8: assert property (@(posedge clk) disable iff (rst)
    (prg_mode == 2'd3 && hi_half) |=> prg_rom_addr[PRG_AW-1:14] == LAST_BANK[PRG_BW-1:0]);

  // R6: in 32KB modes the bank low bit follows the address half
  p_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (!prg_mode[1]) |=> prg_rom_addr[14] == $past(hi_half));

  // R7: lower half in mode 2 is bank 0
  p_fixed_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (prg_mode == 2'd2 && !hi_half) |=> prg_rom_addr[PRG_AW-1:14] == '0);
endmodule

// File: rtl/sbc_chr_map.sv
module sbc_chr_map
  import sbc_pkg::*;
#(
  parameter int unsigned CHR_BANKS = 32,
  localparam int unsigned CHR_BW   = $clog2(CHR_BANKS),
  localparam int unsigned CHR_AW   = CHR_BW + 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [12:0]          ppu_addr,
  input  logic                 split_4k,
  input  logic [SBC_VAL_W-1:0] bank_a,
  input  logic [SBC_VAL_W-1:0] bank_b,
  output logic [CHR_AW-1:0]    chr_addr
);
  logic [SBC_VAL_W-1:0] bank_sel;
  logic                 hi_half;

  assign hi_half = ppu_addr[12];

  always_comb begin
    if (split_4k) bank_sel = hi_half ? bank_b : bank_a;
    else          bank_sel = {bank_a[SBC_VAL_W-1:1], hi_half};
  end

  always_ff @(posedge clk) begin
    if (rst) chr_addr <= '0;
    else     chr_addr <= {bank_sel[CHR_BW-1:0], ppu_addr[11:0]};
  end

  // R9: in 8KB mode the 4KB bank low bit follows address bit 12
  p_chr8k_r9: assert property (@(posedge clk) disable iff (rst)
    (!split_4k) |=> chr_addr[12] == $past(hi_half));

  // R12: offset inside a bank passes through with one cycle of latency
  p_offset_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chr_addr[11:0] == $past(ppu_addr[11:0]));
endmodule

// File: rtl/sbc_bank_ctrl.sv
module sbc_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16,
  parameter int unsigned CHR_BANKS = 32,
  localparam int unsigned PRG_AW   = $clog2(PRG_BANKS) + 14,
  localparam int unsigned CHR_AW   = $clog2(CHR_BANKS) + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [15:0]       cpu_addr,
  input  logic [12:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [1:0]        mirror_mode
);
  sbc_regs_t regs;

  sbc_serial_loader u_loader (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs    (regs)
  );

  sbc_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .prg_mode     (regs.ctrl[3:2]),
    .prg_bank     (regs.prg),
    .prg_rom_addr (prg_rom_addr)
  );

  sbc_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk      (clk),
    .rst      (rst),
    .ppu_addr (ppu_addr),
    .split_4k (regs.ctrl[4]),
    .bank_a   (regs.chr_a),
    .bank_b   (regs.chr_b),
    .chr_addr (chr_addr)
  );

  assign mirror_mode = regs.ctrl[1:0];

  // R11: mirroring only moves on a committed control value
  p_mirror_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(mirror_mode));
endmodule

// File: tb/sbc_bank_ctrl_tb_top.sv
module sbc_bank_ctrl_tb_top;
  localparam int PRG_BANKS = 16;
  localparam int CHR_BANKS = 32;
  localparam int PRG_AW = $clog2(PRG_BANKS) + 14;
  localparam int CHR_AW = $clog2(CHR_BANKS) + 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [1:0] mirror_mode;

  always #5 clk = ~clk;

  sbc_bank_ctrl #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .prg_rom_addr(prg_rom_addr), .chr_addr(chr_addr), .mirror_mode(mirror_mode)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement-level model state
  logic [4:0] m_ctl = 5'h0C, m_ca = '0, m_cb = '0;
  logic [3:0] m_pb = '0;
  logic [4:0] m_sh = 5'b10000;
  int         m_cnt = 0;

  function automatic logic [31:0] exp_prg(logic [15:0] a);
    logic [4:0] b;
    case (m_ctl[3:2])
      2'd0, 2'd1: b = {1'b0, m_pb[3:1], a[14]};
      2'd2:       b = a[14] ? {1'b0, m_pb} : 5'd0;
      default:    b = a[14] ? 5'(PRG_BANKS - 1) : {1'b0, m_pb};
    endcase
    return (32'(b) << 14) | 32'(a[13:0]);
  endfunction

  function automatic logic [31:0] exp_chr(logic [12:0] a);
    logic [4:0] b;
    if (m_ctl[4]) b = a[12] ? m_cb : m_ca;
    else          b = {m_ca[4:1], a[12]};
    return (32'(b) << 12) | 32'(a[11:0]);
  endfunction

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    if (!a[15]) return;
    if (d[7]) begin
      m_sh = 5'b10000; m_cnt = 0; m_ctl[3:2] = 2'b11;
    end else begin
      m_sh = {d[0], m_sh[4:1]};
      m_cnt++;
      if (m_cnt == 5) begin
        case (a[14:13])
          2'd0: m_ctl = m_sh;
          2'd1: m_ca  = m_sh;
          2'd2: m_cb  = m_sh;
          default: m_pb = m_sh[3:0];
        endcase
        m_sh = 5'b10000; m_cnt = 0;
      end
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(logic [15:0] a, logic [4:0] v);
    for (int i = 0; i < 5; i++) bus_wr(a, {7'd0, v[i]});
  endtask

  task automatic push(int kind, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_prg(logic [15:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    cpu_addr = a;
    e = exp_prg(a);
    @(posedge clk); #1;
    push(0, e, tag);
  endtask

  task automatic chk_chr(logic [12:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    ppu_addr = a;
    e = exp_chr(a);
    @(posedge clk); #1;
    push(1, e, tag);
  endtask

  task automatic chk_mir(logic [1:0] e, string tag);
    @(posedge clk); #1;
    push(2, 32'(e), tag);
  endtask

  // monitor: pops expected items and compares between edges
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 32'(prg_rom_addr);
        1: act = 32'(chr_addr);
        default: act = 32'(mirror_mode);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_mir(2'd0, "R1 mirror");
    chk_prg(16'h8000, "R1 prg low");
    chk_prg(16'hC000, "R1 prg high last");
    chk_chr(13'h0000, "R1 chr");
    // R4 + R8: program bank 5, mode 3
    load(16'hE000, 5'd5);
    chk_prg(16'h8123, "R4 prg bank commit");
    chk_prg(16'hC456, "R8 fixed last");
    // R7 + R11: mode 2, vertical
    load(16'h8000, 5'h0A);
    chk_mir(2'd2, "R11 vertical");
    chk_prg(16'h8010, "R7 low fixed 0");
    chk_prg(16'hC001, "R7 high switchable");
    // R6: mode 0, horizontal
    load(16'h8000, 5'h03);
    chk_mir(2'd3, "R11 horizontal");
    chk_prg(16'h8000, "R6 32k low");
    chk_prg(16'hC000, "R6 32k high");
    // R3: bit-7 write -> mode 3, mirror kept
    bus_wr(16'h9000, 8'h80);
    chk_mir(2'd3, "R3 mirror kept");
    chk_prg(16'h8000, "R3 mode forced 3");
    // R2: partial discarded
    bus_wr(16'h8000, 8'h01);
    bus_wr(16'h8000, 8'h01);
    bus_wr(16'h8000, 8'h80);
    load(16'h8000, 5'h11);
    chk_mir(2'd1, "R2 upper screen");
    chk_prg(16'hC000, "R2 mode 0");
    // R10: 4KB pattern banks
    load(16'hA000, 5'd7);
    load(16'hC000, 5'd20);
    chk_chr(13'h0010, "R10 low bank A");
    chk_chr(13'h1020, "R10 high bank B");
    // R9: 8KB pattern bank
    load(16'h8000, 5'h00);
    chk_chr(13'h0005, "R9 8k low");
    chk_chr(13'h1005, "R9 8k high");
    chk_mir(2'd0, "R11 lower screen");
    // R5: low writes interleaved with a sequence
    bus_wr(16'h8000, 8'h00);
    bus_wr(16'h8000, 8'h01);
    for (int i = 0; i < 5; i++) bus_wr(16'h6000, 8'h01);
    bus_wr(16'h7FFF, 8'h80);
    chk_mir(2'd0, "R5 mirror untouched");
    bus_wr(16'h8000, 8'h01);
    bus_wr(16'h8000, 8'h01);
    bus_wr(16'h8000, 8'h00);
    chk_mir(2'd2, "R5 sequence intact");
    chk_prg(16'h8000, "R5 mode 3 after 0E");
    // R12: commit and lookup in the same cycle (mode 3 -> 2)
    for (int i = 0; i < 4; i++) bus_wr(16'h8000, {7'd0, 5'h08 >> i});
    begin
      logic [31:0] e;
      @(negedge clk);
      cpu_addr = 16'hC000;
      e = exp_prg(16'hC000);
      wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h00;
      model_wr(16'h8000, 8'h00);
      @(posedge clk); #1;
      push(0, e, "R12 old mapping at commit edge");
      @(negedge clk);
      wr_en = 1'b0;
      e = exp_prg(16'hC000);
      @(posedge clk); #1;
      push(0, e, "R12 new mapping next edge");
    end
    // R4: fifth bit of program bank dropped
    load(16'hE000, 5'h13);
    chk_prg(16'hC000, "R4 prg low 4 bits");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule